// File: doc/BRIEF.md
# Serial DAC Command Decoder

This block sits on a video acquisition board and turns a slow serial command stream into register-load events for sixteen 12-bit bias converters. A host shifts 24-bit words in, most significant bit first, on a serial data line timed by a serial clock. A frame signal stays high for the duration of each word. All three serial inputs are asynchronous to the system clock, so they pass through a synchronizer before the edges are detected.

A finished word carries three fields. The top nibble is the board address, and it must equal the four jumper inputs. The middle byte selects a function. The low twelve bits carry the value. A matching word either loads one converter channel or updates the integrator gain latch. It loads a channel by giving one system-clock pulse together with the channel number and the value. One function byte resets the FIFOs on every board. That byte acts whatever the address nibble holds, so a single broadcast reaches all boards.

Top module: `dac_cmd_rx`

## Requirements
- R1: While and after reset, `ld_valid` and `fifo_clear` are low and `gain_slow` is 0, which selects the fast, high-gain integrator.
- R2: Serial bits are taken on rising `ser_clk` edges while `ser_frame` is high, first bit into word bit 23. The word is read as address bits 23:20, function byte bits 19:12 and value bits 11:0.
- R3: A word is acted on only when exactly 24 rising serial-clock edges fell inside the frame. Shorter or longer frames produce no output.
- R4: Loads and gain writes take effect only when the address nibble equals `brd_jumper` (installed jumper = 1). A word for another address changes no output.
- R5: Function bytes 0xE0, 0xE4, … 0xFC (step 4) load offset-null channels 0 to 7 in that order. `ld_chan` reports 0 to 7.
- R6: Function byte 0xC0 loads the converter reference, reported as `ld_chan` 15. Bytes 0xC4, 0xC8, … 0xDC load external biases 1 to 7, reported as `ld_chan` 8 to 14.
- R7: Each accepted load produces exactly one `ld_valid` pulse, one system clock wide. `ld_value` equals the word's bits 11:0 during that pulse.
- R8: Function byte 0xC3 copies value bit 0 into `gain_slow` (1 = slow, low gain). `gain_slow` holds until the next accepted gain write.
- R9: Function byte 0xC1 gives a one-clock `fifo_clear` pulse whatever the address nibble and value bits.
- R10: Function bytes outside the lists above produce neither a load nor a FIFO pulse.
- R11: Serial clock edges while `ser_frame` is low are ignored. They neither shift data nor count toward the 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_frame | input | 1 | High while a word is being shifted |
| brd_jumper | input | 4 | Board address from jumpers, installed = 1 |
| ld_valid | output | 1 | One-clock channel load strobe |
| ld_chan | output | 4 | Channel number being loaded |
| ld_value | output | 12 | 12-bit converter value |
| gain_slow | output | 1 | Integrator gain latch, 1 = slow low gain |
| fifo_clear | output | 1 | One-clock broadcast FIFO reset |

## Verification
A table of words walks through all three function groups: offsets, biases and the reference. Each is sent with a different value pattern, so a wrong bit order or field split shows up as a wrong channel or value. The table also holds words with a foreign address, near-miss function bytes (0xC2, 0xE1) and broadcast FIFO resets under foreign addresses and nonzero values. These separate address gating from function decoding. Directed cases cover three more things. Gain writes toggle the latch both ways, with a foreign-address write in between. Frames of 23 and 25 edges are sent to probe the exact bit count. Stray serial clocks outside a frame are sent to show they do not disturb the next word.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

    localparam int WORD_W = 24;
    localparam int ADDR_W = 4;
    localparam int FUNC_W = 8;
    localparam int VAL_W  = 12;
    localparam int CHAN_W = 4;
    localparam int CNT_W  = $clog2(WORD_W + 2);
    localparam int CNT_MAX = WORD_W + 1;

    localparam logic [FUNC_W-1:0] FN_FIFO = 8'hC1;
    localparam logic [FUNC_W-1:0] FN_GAIN = 8'hC3;
    localparam logic [2:0] GRP_OFFSET = 3'b111;
    localparam logic [2:0] GRP_BIAS   = 3'b110;
    localparam logic [CHAN_W-1:0] CHAN_REF  = 4'd15;
    localparam logic [CHAN_W-1:0] BIAS_BASE = 4'd7;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [FUNC_W-1:0] func;
        logic [VAL_W-1:0]  val;
    } cmd_word_t;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_LOAD = 2'd1,
        K_GAIN = 2'd2,
        K_FIFO = 2'd3
    } cmd_kind_t;

    typedef struct packed {
        cmd_kind_t         kind;
        logic [CHAN_W-1:0] chan;
    } cmd_dec_t;

    function automatic cmd_dec_t classify(input logic [FUNC_W-1:0] fn);
        cmd_dec_t d;
        logic [2:0] idx;
        d.kind = K_NONE;
        d.chan = '0;
        idx = fn[4:2];
        if (fn == FN_FIFO) begin
            d.kind = K_FIFO;
        end else if (fn == FN_GAIN) begin
            d.kind = K_GAIN;
        end else if (fn[1:0] == 2'b00) begin
            if (fn[7:5] == GRP_OFFSET) begin
                d.kind = K_LOAD;
                d.chan = {1'b0, idx};
            end else if (fn[7:5] == GRP_BIAS) begin
                d.kind = K_LOAD;
                d.chan = (idx == 3'd0) ? CHAN_REF : BIAS_BASE + {1'b0, idx};
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '0;
                    else     stage_q[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/dac_shift.sv
module dac_shift
    import dac_cmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      s_clk,
    input  logic      s_dat,
    input  logic      s_frame,
    output logic      word_stb,
    output cmd_word_t word
);

    logic              clk_q;
    logic              frame_q;
    logic [WORD_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              edge_rise;
    logic              frame_fall;

    assign edge_rise  = s_clk & ~clk_q;
    assign frame_fall = frame_q & ~s_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_q    <= 1'b0;
            frame_q  <= 1'b0;
            sh_q     <= '0;
            cnt_q    <= '0;
            word_stb <= 1'b0;
        end else begin
            clk_q    <= s_clk;
            frame_q  <= s_frame;
            word_stb <= frame_fall && (cnt_q == CNT_W'(WORD_W));
            if (s_frame) begin
                if (edge_rise) begin
                    sh_q <= {sh_q[WORD_W-2:0], s_dat};
                    if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    assign word = cmd_word_t'(sh_q);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(CNT_MAX)); // R3
    AST_NO_SHIFT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !s_frame |=> $stable(sh_q)); // R11

endmodule

// File: rtl/dac_decode.sv
module dac_decode
    import dac_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              word_stb,
    input  cmd_word_t         word,
    input  logic [ADDR_W-1:0] brd_addr,
    output logic              ld_valid,
    output logic [CHAN_W-1:0] ld_chan,
    output logic [VAL_W-1:0]  ld_value,
    output logic              gain_slow,
    output logic              fifo_clear
);

    cmd_dec_t dec;
    logic     addr_ok;

    assign dec     = classify(word.func);
    assign addr_ok = (word.addr == brd_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_valid   <= 1'b0;
            ld_chan    <= '0;
            ld_value   <= '0;
            gain_slow  <= 1'b0;
            fifo_clear <= 1'b0;
        end else begin
            ld_valid   <= word_stb && addr_ok && (dec.kind == K_LOAD);
            fifo_clear <= word_stb && (dec.kind == K_FIFO);
            if (word_stb && addr_ok && dec.kind == K_LOAD) begin
                ld_chan  <= dec.chan;
                ld_value <= word.val;
            end
            if (word_stb && addr_ok && dec.kind == K_GAIN) begin
                gain_slow <= word.val[0];
            end
        end
    end

    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (rst)
        ld_valid |=> !ld_valid); // R7
    AST_FIFO_PULSE: assert property (@(posedge clk) disable iff (rst)
        fifo_clear |=> !fifo_clear); // R9
    AST_LOAD_FROM_WORD: assert property (@(posedge clk) disable iff (rst)
        ld_valid |-> $past(word_stb)); // R3
    AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(word_stb) |-> $stable(gain_slow)); // R8
    AST_ONE_KIND: assert property (@(posedge clk) disable iff (rst)
        !(ld_valid && fifo_clear)); // R10

endmodule

// File: rtl/dac_cmd_rx.sv
module dac_cmd_rx
    import dac_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ser_clk,
    input  logic        ser_dat,
    input  logic        ser_frame,
    input  logic [3:0]  brd_jumper,
    output logic        ld_valid,
    output logic [3:0]  ld_chan,
    output logic [11:0] ld_value,
    output logic        gain_slow,
    output logic        fifo_clear
);

    logic [2:0] raw_in;
    logic [2:0] sync_out;
    logic       word_stb;
    cmd_word_t  word;

    assign raw_in = {ser_frame, ser_dat, ser_clk};

    dac_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (raw_in),
        .d_out (sync_out)
    );

    dac_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .s_clk    (sync_out[0]),
        .s_dat    (sync_out[1]),
        .s_frame  (sync_out[2]),
        .word_stb (word_stb),
        .word     (word)
    );

    dac_decode u_dec (
        .clk        (clk),
        .rst        (rst),
        .word_stb   (word_stb),
        .word       (word),
        .brd_addr   (brd_jumper),
        .ld_valid   (ld_valid),
        .ld_chan    (ld_chan),
        .ld_value   (ld_value),
        .gain_slow  (gain_slow),
        .fifo_clear (fifo_clear)
    );

endmodule

// File: tb/sim_dac_cmd_rx.sv
module sim_dac_cmd_rx;

    localparam int CLK_P = 10;
    localparam int WDOG  = 100000;
    localparam int NV    = 12;
    localparam logic [3:0] BRD = 4'hA;

    localparam logic [23:0] V_WORD [NV] = '{
        24'hAE0123, 24'hAFCFFF, 24'hAEC055, 24'hAC0800,
        24'hAC4001, 24'hADCABC, 24'hAD0321, 24'h5E0111,
        24'hAC2222, 24'hAE1333, 24'h3C1000, 24'hAC17FF };
    localparam logic V_LD [NV] = '{1,1,1,1, 1,1,1,0, 0,0,0,0};
    localparam logic [3:0] V_CH [NV] = '{0,7,3,15, 8,14,11,0, 0,0,0,0};
    localparam logic V_FF [NV] = '{0,0,0,0, 0,0,0,0, 0,0,1,1};
    string v_tag [NV] = '{"R5","R5","R5","R6","R6","R6","R6","R4",
                          "R10","R10","R9","R9"};

    logic clk = 0;
    logic rst = 1;
    logic ser_clk = 0, ser_dat = 0, ser_frame = 0;
    logic [3:0] brd_jumper = BRD;
    logic ld_valid, gain_slow, fifo_clear;
    logic [3:0] ld_chan;
    logic [11:0] ld_value;

    int tests = 0, fails = 0;
    int ld_cnt = 0, ff_cnt = 0;
    logic [3:0]  seen_chan = 0;
    logic [11:0] seen_val = 0;

    always #(CLK_P/2) clk = ~clk;

    dac_cmd_rx u0 (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_frame(ser_frame), .brd_jumper(brd_jumper),
        .ld_valid(ld_valid), .ld_chan(ld_chan), .ld_value(ld_value),
        .gain_slow(gain_slow), .fifo_clear(fifo_clear)
    );

    always @(negedge clk) begin
        if (ld_valid) begin
            ld_cnt <= ld_cnt + 1;
            seen_chan <= ld_chan;
            seen_val <= ld_value;
        end
        if (fifo_clear) ff_cnt <= ff_cnt + 1;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic half();
        repeat (3) @(negedge clk);
    endtask

    task automatic send(input logic [23:0] w, input int n);
        half();
        ser_frame = 1;
        half();
        for (int i = 0; i < n; i++) begin
            ser_dat = (i < 24) ? w[23-i] : 1'b0;
            half();
            ser_clk = 1;
            half();
            ser_clk = 0;
        end
        half();
        ser_frame = 0;
        repeat (12) @(negedge clk);
    endtask

    task automatic send_check(input logic [23:0] w, input int n, input bit e_ld,
                              input logic [3:0] e_ch, input bit e_ff,
                              input string tag);
        int l0, f0;
        l0 = ld_cnt;
        f0 = ff_cnt;
        send(w, n);
        // one single-cycle pulse per accepted load (R7)
        check((ld_cnt - l0) == (e_ld ? 1 : 0), tag, "load pulse cycles",
              ld_cnt - l0, e_ld ? 1 : 0);
        check((ff_cnt - f0) == (e_ff ? 1 : 0), tag, "fifo pulse cycles",
              ff_cnt - f0, e_ff ? 1 : 0);
        if (e_ld) begin
            check(seen_chan == e_ch, tag, "channel", seen_chan, e_ch);
            // value field placement, R2
            check(seen_val == w[11:0], "R2", "value", seen_val, w[11:0]);
        end
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL R7 watchdog actual=%0d expected=%0d", WDOG, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        check(!ld_valid && !fifo_clear && !gain_slow, "R1", "in reset",
              {ld_valid, fifo_clear, gain_slow}, 0);
        rst = 0;
        repeat (3) @(negedge clk);
        check(!ld_valid && !fifo_clear && !gain_slow, "R1", "after reset",
              {ld_valid, fifo_clear, gain_slow}, 0);

        for (int i = 0; i < NV; i++)
            send_check(V_WORD[i], 24, V_LD[i], V_CH[i], V_FF[i], v_tag[i]);

        // R8: gain latch toggles and holds; foreign address ignored (R4)
        send_check(24'hAC3001, 24, 0, 0, 0, "R8");
        check(gain_slow == 1'b1, "R8", "gain set", gain_slow, 1);
        send_check(24'h4C3000, 24, 0, 0, 0, "R4");
        check(gain_slow == 1'b1, "R4", "foreign gain write", gain_slow, 1);
        send_check(24'hAE2222, 24, 0, 0, 0, "R10");
        check(gain_slow == 1'b1, "R8", "gain held", gain_slow, 1);
        send_check(24'hAC3FFE, 24, 0, 0, 0, "R8");
        check(gain_slow == 1'b0, "R8", "gain cleared", gain_slow, 0);

        // R3: short and long frames discarded
        send_check(24'hAE4456, 23, 0, 0, 0, "R3");
        send_check(24'hAE4456, 25, 0, 0, 0, "R3");
        send_check(24'h0C1000, 23, 0, 0, 0, "R3");
        send_check(24'hAE4456, 24, 1, 1, 0, "R3");

        // R11: stray serial clocks outside a frame
        ser_dat = 1;
        for (int k = 0; k < 5; k++) begin
            half();
            ser_clk = 1;
            half();
            ser_clk = 0;
        end
        send_check(24'hAF0A5A, 24, 1, 4, 0, "R11");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule